// File: doc/BRIEF.md
# Multi-Channel Packet DMA Engine

This block moves packet data between system memory and the endpoint FIFOs of a USB-style device or host controller. It has eight independent channels. Software gives each channel a memory address, a byte count and a control word, and the write that sets the enable bit starts the channel. The FIFO side is not modelled. Each channel splits its work into bursts and presents them on a shared request/acknowledge memory port. A round-robin arbiter picks one channel for each burst. A channel can run in one of two modes. In single-packet mode (mode 0) it moves one packet and stops. In multi-packet mode (mode 1) it waits for its endpoint's request line before each packet and stops when its count reaches zero.

The address register advances live as bursts complete, so software finds the number of bytes moved by subtracting the start address from the current address. When a channel finishes, hardware clears its enable bit and sets its flag in a shared status word. An error reported by the memory port also ends the channel, and in that case the channel sets an error bit in its own control word. If software writes a control word with enable clear to an active channel, the channel stops at once without raising a flag.

Each channel runs the state machine CH_IDLE, CH_WAIT_EP, CH_BURST and CH_DONE:
- A start in CH_IDLE or CH_DONE goes to CH_DONE when the count or the packet size is zero. Otherwise it goes to CH_WAIT_EP in mode 1, or to CH_BURST in mode 0.
- CH_WAIT_EP goes to CH_BURST on the endpoint request.
- CH_BURST stays in CH_BURST on an acknowledge that leaves bytes in the packet. At the end of a packet it goes to CH_WAIT_EP when it is in mode 1 and bytes remain, and to CH_DONE otherwise. A bus error sends it to CH_DONE.
- An abort sends CH_WAIT_EP or CH_BURST to CH_IDLE.
- CH_DONE returns to CH_IDLE after one cycle.

The arbiter runs the state machine ARB_IDLE and ARB_HOLD. ARB_IDLE picks the next requester in round-robin order and goes to ARB_HOLD. ARB_HOLD returns to ARB_IDLE on the acknowledge, or when the owning channel drops its request.

Top module: `pkt_dma_engine`

## Requirements
- R1: The interrupt status word is at byte address 0x200. Channel n has its control word at 0x204+16n, its memory address at 0x208+16n and its byte count (17 bits, at most 0x10000) at 0x20C+16n. The control word has these fields: bit 0 enable, bit 1 direction (1 means memory to FIFO), bit 2 mode 1, bit 3 interrupt enable, bits 7:4 endpoint, bit 8 bus error, bits 10:9 burst type. An idle channel reads back exactly what was written to each of these registers. After reset, all of them read zero.
- R2: In mode 0 a channel moves min(count, packet size) bytes and then completes. At completion the address has grown by the number of bytes moved and the count has shrunk by the same amount.
- R3: Each request carries the channel's burst type on mem_burst. Its length is the smaller of the bytes left in the packet and the burst size, which is 4, 16, 32 or 64 bytes for types 0, 1, 2 and 3. Its address is the channel's current address.
- R4: In mode 1 a channel makes no request until ep_req[endpoint] is high in a cycle. It then moves one packet and waits again. It completes when the count reaches zero, and its last packet may be short.
- R5: When several channels request, each grant covers one burst, and grants go round robin in ascending channel order starting after the last channel served.
- R6: An error on the acknowledged burst sets control bit 8, ends the channel, and sets its status flag. The address and count keep the values they had before the failing burst.
- R7: A control write with enable clear to an active channel returns it to idle at once. The channel's request drops in the next cycle, no status flag is set, and later endpoint requests have no effect.
- R8: Status bit n is set when channel n completes, and a read of the status word clears it. irq is the OR of the status bits whose channel has interrupt enable set.
- R9: Hardware clears the enable bit when a channel completes. Writes to the address and count of an active channel are ignored.
- R10: A start with a count of zero completes without any memory request.
- R11: mem_to_fifo carries the direction bit, and mem_ep and mem_chan carry the endpoint number and the channel index of the channel being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the status word clears it |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, decoded from reg_addr in the same cycle |
| irq | output | 1 | Interrupt of enabled completed channels |
| ep_req | input | 16 | Per-endpoint packet request lines for mode 1 |
| ch_pkt_size | input | NCH*11 | Packet size in bytes, 11 bits per channel |
| mem_req | output | 1 | Burst request to memory |
| mem_ack | input | 1 | Burst completed |
| mem_err | input | 1 | Burst failed, valid with mem_ack |
| mem_addr | output | 32 | Burst start address |
| mem_len | output | 7 | Burst length in bytes |
| mem_burst | output | 2 | Burst type hint |
| mem_to_fifo | output | 1 | 1 when the memory is read and the FIFO filled |
| mem_ep | output | 4 | Endpoint of the channel being served |
| mem_chan | output | 3 | Index of the channel being served |

## Verification
On every cycle the assertions check the following. At most one channel sees an acknowledge. The grant owner stays stable while its burst is outstanding, and a contested pick moves away from the last channel served. A channel's packet remainder stays nonzero and within its count. An error sends the channel to completion with the error bit set, and an abort returns it to idle. The enable bit clears after completion, and a completion always leaves a status bit set. Only the bench scenarios can show the rest: the exact burst lengths and addresses for each burst type, the order in which contending channels are served, the bytes moved as seen through the address register, the wait for each endpoint request in mode 1, and the masking of the interrupt by its enable bit.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int CTRL_W = 11;
    localparam int EP_W   = 4;
    localparam int EP_N   = 1 << EP_W;
    localparam int LEN_W  = 7;

    localparam logic [11:0] REG_BASE = 12'h200;
    localparam logic [3:0]  OFF_STAT = 4'h0;
    localparam logic [3:0]  OFF_CTRL = 4'h4;
    localparam logic [3:0]  OFF_ADDR = 4'h8;
    localparam logic [3:0]  OFF_CNT  = 4'hC;

    typedef enum logic [1:0] {CH_IDLE, CH_WAIT_EP, CH_BURST, CH_DONE} ch_state_e;
    typedef enum logic {ARB_IDLE, ARB_HOLD} arb_state_e;

    typedef struct packed {
        logic [1:0]      burst;
        logic            berr;
        logic [EP_W-1:0] ep;
        logic            ie;
        logic            mode1;
        logic            dir;
        logic            en;
    } ctrl_t;

    function automatic logic [LEN_W-1:0] burst_bytes(input logic [1:0] kind);
        unique case (kind)
            2'd0: return 7'd4;
            2'd1: return 7'd16;
            2'd2: return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 17,
    parameter int PKW = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_addr,
    input  logic                wr_cnt,
    input  logic [31:0]         wdata,
    input  logic [PKW-1:0]      pkt_size,
    input  logic [EP_N-1:0]     ep_req,
    input  logic                ack,
    input  logic                err,
    output logic                req,
    output logic [LEN_W-1:0]    req_len,
    output ctrl_t               ctrl_o,
    output logic [AW-1:0]       addr_o,
    output logic [CW-1:0]       cnt_o,
    output logic                done
);

    ch_state_e      state_q, state_d;
    ctrl_t          ctrl_q;
    logic [AW-1:0]  addr_q;
    logic [CW-1:0]  cnt_q;
    logic [PKW-1:0] pkt_left;

    logic           ready, active, start, abort, ep_hit, pkt_end;
    logic [PKW-1:0] bb_w, chunk_w, first_pkt;

    always_comb begin
        ready     = (state_q == CH_IDLE) || (state_q == CH_DONE);
        active    = (state_q == CH_WAIT_EP) || (state_q == CH_BURST);
        start     = wr_ctrl && wdata[0] && ready;
        abort     = wr_ctrl && !wdata[0] && active;
        ep_hit    = ep_req[ctrl_q.ep];
        bb_w      = PKW'(burst_bytes(ctrl_q.burst));
        chunk_w   = (pkt_left < bb_w) ? pkt_left : bb_w;
        pkt_end   = (chunk_w == pkt_left);
        first_pkt = (cnt_q < CW'(pkt_size)) ? cnt_q[PKW-1:0] : pkt_size;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE, CH_DONE: begin
                state_d = CH_IDLE;
                if (start) begin
                    if (cnt_q == '0 || pkt_size == '0) state_d = CH_DONE;
                    else if (wdata[2])                 state_d = CH_WAIT_EP;
                    else                               state_d = CH_BURST;
                end
            end
            CH_WAIT_EP: begin
                if (abort)       state_d = CH_IDLE;
                else if (ep_hit) state_d = CH_BURST;
            end
            CH_BURST: begin
                if (abort) state_d = CH_IDLE;
                else if (ack) begin
                    if (err) state_d = CH_DONE;
                    else if (pkt_end)
                        state_d = (ctrl_q.mode1 && cnt_q != CW'(chunk_w)) ? CH_WAIT_EP : CH_DONE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // register file and transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            addr_q   <= '0;
            cnt_q    <= '0;
            pkt_left <= '0;
        end else begin
            if (wr_addr && !active) addr_q <= wdata[AW-1:0];
            if (wr_cnt && !active)  cnt_q  <= wdata[CW-1:0];
            if (state_q == CH_BURST && ack && !abort) begin
                if (err) ctrl_q.berr <= 1'b1;
                else begin
                    addr_q   <= addr_q + AW'(chunk_w);
                    cnt_q    <= cnt_q - CW'(chunk_w);
                    pkt_left <= pkt_left - chunk_w;
                end
            end
            if (state_q == CH_DONE) ctrl_q.en <= 1'b0;
            if (wr_ctrl && (ready || abort)) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (state_d == CH_BURST && state_q != CH_BURST) pkt_left <= first_pkt;
        end
    end

    // outputs
    always_comb begin
        req     = (state_q == CH_BURST);
        done    = (state_q == CH_DONE);
        req_len = chunk_w[LEN_W-1:0];
        ctrl_o  = ctrl_q;
        addr_o  = addr_q;
        cnt_o   = cnt_q;
    end

    // R2: a packet in flight never exceeds the bytes still owed
    a_r2_pkt_within_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_BURST) |-> (pkt_left != '0 && CW'(pkt_left) <= cnt_q));

    a_r6_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_BURST && ack && err && !wr_ctrl) |=> (state_q == CH_DONE && ctrl_q.berr));

    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == CH_IDLE && !req));

    a_r9_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DONE && !wr_ctrl) |=> !ctrl_q.en);

endmodule

// File: rtl/pdma_rr_arb.sv
module pdma_rr_arb
    import pdma_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           ack,
    output logic           grant,
    output logic [IW-1:0]  owner
);

    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, last_q, pick_idx, cand;
    logic          pick_valid;

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = last_q;
        for (int i = 1; i <= NCH; i++) begin
            cand = IW'((int'(last_q) + i) % NCH);
            if (!pick_valid && req[cand]) begin
                pick_valid = 1'b1;
                pick_idx   = cand;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (pick_valid) state_d = ARB_HOLD;
            ARB_HOLD: if (ack || !req[owner_q]) state_d = ARB_IDLE;
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= '0;
            last_q  <= IW'(NCH - 1);
        end else if (state_q == ARB_IDLE && pick_valid) begin
            owner_q <= pick_idx;
            last_q  <= pick_idx;
        end
    end

    always_comb begin
        grant = (state_q == ARB_HOLD) && req[owner_q];
        owner = owner_q;
    end

    a_r5_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HOLD && !ack && req[owner_q]) |=> (state_q == ARB_HOLD && owner_q == $past(owner_q)));

    a_r5_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && $countones(req) > 1) |=> (owner_q != $past(last_q)));

endmodule

// File: rtl/pkt_dma_engine.sv
module pkt_dma_engine
    import pdma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 32,
    parameter int CW  = 17,
    parameter int PKW = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [11:0]              reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     irq,
    input  logic [15:0]              ep_req,
    input  logic [NCH*PKW-1:0]       ch_pkt_size,
    output logic                     mem_req,
    input  logic                     mem_ack,
    input  logic                     mem_err,
    output logic [AW-1:0]            mem_addr,
    output logic [6:0]               mem_len,
    output logic [1:0]               mem_burst,
    output logic                     mem_to_fifo,
    output logic [3:0]               mem_ep,
    output logic [$clog2(NCH)-1:0]   mem_chan
);

    localparam int IW = $clog2(NCH);
    localparam logic [11:0] REG_END = 12'(int'(REG_BASE) + NCH * 16);

    logic           win, stat_clr;
    logic [IW-1:0]  sel, owner;
    logic [3:0]     off;
    logic           grant;
    logic [NCH-1:0] req_v, done_v, ack_v, ie_v, status_q;

    ctrl_t            ctrl_v [NCH];
    logic [AW-1:0]    addr_v [NCH];
    logic [CW-1:0]    cnt_v  [NCH];
    logic [LEN_W-1:0] len_v  [NCH];

    always_comb begin
        win      = (reg_addr >= REG_BASE) && (reg_addr < REG_END);
        sel      = reg_addr[4 +: IW];
        off      = reg_addr[3:0];
        stat_clr = reg_rd && win && off == OFF_STAT && sel == '0;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit      = reg_wr && win && sel == IW'(i);
        assign ack_v[i] = mem_ack && grant && owner == IW'(i);
        assign ie_v[i]  = ctrl_v[i].ie;

        pdma_channel #(.AW(AW), .CW(CW), .PKW(PKW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (hit && off == OFF_CTRL),
            .wr_addr  (hit && off == OFF_ADDR),
            .wr_cnt   (hit && off == OFF_CNT),
            .wdata    (reg_wdata),
            .pkt_size (ch_pkt_size[i*PKW +: PKW]),
            .ep_req   (ep_req),
            .ack      (ack_v[i]),
            .err      (mem_err),
            .req      (req_v[i]),
            .req_len  (len_v[i]),
            .ctrl_o   (ctrl_v[i]),
            .addr_o   (addr_v[i]),
            .cnt_o    (cnt_v[i]),
            .done     (done_v[i])
        );
    end

    pdma_rr_arb #(.NCH(NCH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_v),
        .ack   (mem_ack),
        .grant (grant),
        .owner (owner)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (stat_clr ? '0 : status_q) | done_v;
    end

    always_comb begin
        mem_req     = grant;
        mem_addr    = addr_v[owner];
        mem_len     = len_v[owner];
        mem_burst   = ctrl_v[owner].burst;
        mem_to_fifo = ctrl_v[owner].dir;
        mem_ep      = ctrl_v[owner].ep;
        mem_chan    = owner;
        irq         = |(status_q & ie_v);
    end

    always_comb begin
        reg_rdata = '0;
        if (win) begin
            unique case (off)
                OFF_STAT: reg_rdata = (sel == '0) ? 32'(status_q) : '0;
                OFF_CTRL: reg_rdata = 32'(ctrl_v[sel]);
                OFF_ADDR: reg_rdata = 32'(addr_v[sel]);
                OFF_CNT:  reg_rdata = 32'(cnt_v[sel]);
                default:  reg_rdata = '0;
            endcase
        end
    end

    a_r5_one_ack: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack_v));

    a_r8_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_v) |=> (|status_q));

endmodule

// File: tb/tb_pkt_dma_engine.sv
`timescale 1ns/1ps
module tb_pkt_dma_engine;

    localparam int NCH = 8;
    localparam int PKW = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq;
    logic [15:0] ep_req = '0;
    logic [NCH*PKW-1:0] ch_pkt_size;
    logic        mem_req, mem_ack, mem_err;
    logic [31:0] mem_addr;
    logic [6:0]  mem_len;
    logic [1:0]  mem_burst;
    logic        mem_to_fifo;
    logic [3:0]  mem_ep;
    logic [2:0]  mem_chan;

    logic [PKW-1:0] pkt [NCH];

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) ch_pkt_size[i*PKW +: PKW] = pkt[i];
    end

    pkt_dma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .ep_req(ep_req),
        .ch_pkt_size(ch_pkt_size), .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_burst(mem_burst),
        .mem_to_fifo(mem_to_fifo), .mem_ep(mem_ep), .mem_chan(mem_chan)
    );

    int errs = 0, checks = 0;
    bit finished = 0;

    // memory model and burst log
    bit        slave_on = 1;
    bit        err_arm = 0;
    int        err_ch = 0, err_skip = 0;
    int        log_n = 0;
    int        log_chan [64];
    logic [31:0] log_addr [64];
    int        log_len [64];
    int        log_burst [64];
    int        log_dir [64];
    int        log_ep [64];

    initial begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req && slave_on) begin
                if (log_n < 64) begin
                    log_chan[log_n]  = int'(mem_chan);
                    log_addr[log_n]  = mem_addr;
                    log_len[log_n]   = int'(mem_len);
                    log_burst[log_n] = int'(mem_burst);
                    log_dir[log_n]   = int'(mem_to_fifo);
                    log_ep[log_n]    = int'(mem_ep);
                end
                log_n++;
                mem_ack = 1'b1;
                if (err_arm && int'(mem_chan) == err_ch) begin
                    if (err_skip == 0) begin
                        mem_err = 1'b1;
                        err_arm = 0;
                    end else err_skip--;
                end
            end
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [11:0] ra(input int ch, input int off);
        return 12'(32'h200 + ch * 16 + off);
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit en, input bit dir, input bit m1, input bit ie,
                                            input int ep, input int burst);
        return {21'b0, 2'(burst), 1'b0, 4'(ep), ie, m1, dir, en};
    endfunction

    function automatic int bsize(input int b);
        return (b == 0) ? 4 : (b == 1) ? 16 : (b == 2) ? 32 : 64;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic ep_pulse(input int ep);
        @(negedge clk);
        ep_req[ep] = 1'b1;
        @(negedge clk);
        ep_req = '0;
    endtask

    // mode-0 vectors: {count, packet size, burst type, direction, endpoint}
    localparam logic [34:0] VEC [5] = '{
        {17'd100,     11'd64,  2'd3, 1'b1, 4'd1},
        {17'd40,      11'd64,  2'd1, 1'b0, 4'd2},
        {17'd200,     11'd512, 2'd2, 1'b1, 4'd9},
        {17'd10,      11'd8,   2'd0, 1'b0, 4'd15},
        {17'h10000,   11'd64,  2'd0, 1'b1, 4'd4}
    };

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NCH; i++) pkt[i] = 11'd64;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        chk("R1", "reset mem_req", longint'(mem_req), 0);
        chk("R8", "reset irq", longint'(irq), 0);
        rd(ra(0, 0), d);  chk("R8", "reset status", d, 0);
        rd(ra(0, 4), d);  chk("R1", "reset ctrl0", d, 0);
        rd(ra(3, 12), d); chk("R1", "reset count3", d, 0);

        // register readback while idle
        wr(ra(3, 8), 32'h1234_5678);
        wr(ra(3, 12), 32'h0001_0000);
        wr(ra(3, 4), mk_ctrl(0, 1, 1, 1, 5, 2));
        rd(ra(3, 8), d);  chk("R1", "addr3 readback", d, 32'h1234_5678);
        rd(ra(3, 12), d); chk("R1", "count3 readback", d, 32'h0001_0000);
        rd(ra(3, 4), d);  chk("R1", "ctrl3 readback", d, mk_ctrl(0, 1, 1, 1, 5, 2));

        // table walk: mode 0 on channels 0..4
        for (int i = 0; i < 5; i++) begin
            int cnt, pk, bt, dr, ep, moved, nb, exp_len, off;
            logic [31:0] base;
            bit bad;
            cnt = int'(VEC[i][34:18]); pk = int'(VEC[i][17:7]);
            bt = int'(VEC[i][6:5]); dr = int'(VEC[i][4]); ep = int'(VEC[i][3:0]);
            moved = (cnt < pk) ? cnt : pk;
            nb = (moved + bsize(bt) - 1) / bsize(bt);
            base = 32'h1000_0000 + 32'(i) * 32'h0001_0000;
            pkt[i] = 11'(pk);
            log_n = 0;
            wr(ra(i, 8), base);
            wr(ra(i, 12), 32'(cnt));
            wr(ra(i, 4), mk_ctrl(1, dr[0], 0, 1, ep, bt));
            wait_irq();
            idle(2);
            rd(ra(0, 0), d);  chk("R8", "status after mode0", d, 32'(1) << i);
            rd(ra(i, 8), d);  chk("R2", "address advanced", d, base + 32'(moved));
            rd(ra(i, 12), d); chk("R2", "count remaining", d, 32'(cnt - moved));
            rd(ra(i, 4), d);  chk("R9", "enable cleared", d, mk_ctrl(0, dr[0], 0, 1, ep, bt));
            chk("R3", "burst count", log_n, nb);
            bad = 0; off = 0;
            for (int k = 0; k < nb && k < 64; k++) begin
                exp_len = (moved - off < bsize(bt)) ? moved - off : bsize(bt);
                if (log_len[k] != exp_len || log_addr[k] != base + 32'(off) || log_burst[k] != bt)
                    bad = 1;
                off += exp_len;
            end
            chk("R3", "burst lengths/addresses/type", longint'(bad), 0);
            chk("R11", "direction on port", log_dir[0], dr);
            chk("R11", "endpoint and channel on port", log_ep[0] * 16 + log_chan[0], ep * 16 + i);
            rd(ra(0, 0), d);  chk("R8", "status cleared by read", d, 0);
            chk("R8", "irq low after clear", longint'(irq), 0);
        end

        // mode 1 on channel 2, endpoint 6
        pkt[2] = 11'd64;
        log_n = 0;
        wr(ra(2, 8), 32'h2000_0000);
        wr(ra(2, 12), 32'd150);
        wr(ra(2, 4), mk_ctrl(1, 1, 1, 1, 6, 3));
        idle(20);
        chk("R4", "no request before ep_req", log_n, 0);
        wr(ra(2, 8), 32'h0000_DEAD);
        wr(ra(2, 12), 32'd5);
        rd(ra(2, 8), d);  chk("R9", "address write ignored while active", d, 32'h2000_0000);
        rd(ra(2, 12), d); chk("R9", "count write ignored while active", d, 150);
        ep_pulse(6); idle(30);
        chk("R4", "one packet after first ep_req", log_n * 256 + log_len[0], 256 + 64);
        rd(ra(2, 12), d); chk("R4", "count after first packet", d, 86);
        rd(ra(2, 4), d);  chk("R4", "still enabled between packets", d & 1, 1);
        ep_pulse(6); idle(30);
        chk("R4", "second packet", log_n, 2);
        ep_pulse(6); wait_irq(); idle(2);
        chk("R4", "short last packet", log_n * 256 + log_len[2], 3 * 256 + 22);
        rd(ra(2, 8), d);  chk("R4", "address after mode1", d, 32'h2000_0000 + 150);
        rd(ra(0, 0), d);  chk("R4", "status after mode1", d, 32'h4);

        // round robin on channels 0..2
        slave_on = 0;
        log_n = 0;
        for (int c = 0; c < 3; c++) begin
            pkt[c] = 11'd64;
            wr(ra(c, 8), 32'h3000_0000 + 32'(c) * 32'h100);
            wr(ra(c, 12), 32'd48);
            wr(ra(c, 4), mk_ctrl(1, 0, 0, 1, c, 1));
        end
        slave_on = 1;
        for (int k = 0; k < 300 && log_n < 9; k++) @(negedge clk);
        idle(10);
        begin
            bit bad = 0;
            for (int k = 0; k < 9; k++) if (log_chan[k] != k % 3) bad = 1;
            chk("R5", "round-robin order 0,1,2 repeated", longint'(bad), 0);
        end
        chk("R5", "total bursts", log_n, 9);
        rd(ra(0, 0), d); chk("R5", "all three complete", d, 32'h7);

        // bus error on second burst of channel 4
        pkt[4] = 11'd64;
        log_n = 0;
        err_ch = 4; err_skip = 1; err_arm = 1;
        wr(ra(4, 8), 32'h4000_0000);
        wr(ra(4, 12), 32'd64);
        wr(ra(4, 4), mk_ctrl(1, 0, 0, 1, 0, 1));
        wait_irq(); idle(4);
        chk("R6", "bursts until error", log_n, 2);
        rd(ra(0, 0), d);  chk("R6", "status after error", d, 32'h10);
        rd(ra(4, 4), d);  chk("R6", "error bit set, enable clear", d, mk_ctrl(0, 0, 0, 1, 0, 1) | 32'h100);
        rd(ra(4, 8), d);  chk("R6", "address before failing burst", d, 32'h4000_0010);
        rd(ra(4, 12), d); chk("R6", "count before failing burst", d, 48);

        // zero count
        log_n = 0;
        wr(ra(6, 12), 32'd0);
        wr(ra(6, 4), mk_ctrl(1, 0, 0, 1, 0, 0));
        wait_irq(); idle(2);
        chk("R10", "zero count makes no request", log_n, 0);
        rd(ra(0, 0), d); chk("R10", "zero count completes", d, 32'h40);

        // interrupt masking
        wr(ra(7, 12), 32'd0);
        wr(ra(7, 4), mk_ctrl(1, 0, 0, 0, 0, 0));
        idle(10);
        chk("R8", "masked channel leaves irq low", longint'(irq), 0);
        rd(ra(0, 0), d); chk("R8", "masked channel still flags", d, 32'h80);

        // abort while waiting for the endpoint
        log_n = 0;
        wr(ra(5, 8), 32'h5000_0000);
        wr(ra(5, 12), 32'd100);
        wr(ra(5, 4), mk_ctrl(1, 0, 1, 1, 3, 1));
        idle(5);
        wr(ra(5, 4), 32'd0);
        wr(ra(5, 8), 32'd0);
        wr(ra(5, 12), 32'd0);
        ep_pulse(3); idle(20);
        chk("R7", "no request after abort", log_n, 0);
        chk("R7", "no irq after abort", longint'(irq), 0);
        rd(ra(0, 0), d); chk("R7", "no status flag after abort", d, 0);

        // abort with a burst outstanding
        slave_on = 0;
        wr(ra(5, 8), 32'h5100_0000);
        wr(ra(5, 12), 32'd64);
        wr(ra(5, 4), mk_ctrl(1, 0, 0, 1, 0, 1));
        for (int k = 0; k < 20 && !mem_req; k++) @(negedge clk);
        chk("R7", "request pending before abort", longint'(mem_req) * 8 + longint'(mem_chan), 8 + 5);
        wr(ra(5, 4), 32'd0);
        chk("R7", "request dropped after abort", longint'(mem_req), 0);
        slave_on = 1;
        idle(20);
        chk("R7", "no burst served after abort", log_n, 0);
        rd(ra(0, 0), d); chk("R7", "no flag after mid-burst abort", d, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule